// File: doc/BRIEF.md
# Priority-Based Reference Input Selector

This block decides which of four reference clock inputs should drive a downstream phase-locked loop. It handles only the decision and never touches the clock signals. The block works out each input's health from two alarm lines, a loss of signal alarm and an out of frequency alarm. Each alarm has its own mask bit, and a masked alarm does not count. The block then chooses an input index, either from a manual request or by automatic ranking on per-input priorities.

Automatic selection has two variants. In the revertive variant the best healthy input is always chosen. In the non-revertive variant the current input is kept for as long as it stays healthy. If no usable input exists, the block asks the loop to enter holdover. A one-cycle strobe marks every change of the chosen index. When zero-delay operation is on, the last input carries the loop feedback, so it is removed from every choice.

Top module: `ref_clk_selector`

## Requirements
- R1: While reset is held, and after it is released with an idle configuration, `selIdx` is 0 and `switchPulse` and `holdReq` are both 0.
- R2: `modeSel` codes 2'b00 and 2'b11 are manual. In manual mode `manualFromReg`=1 selects `regSel`, `manualFromReg`=0 selects `pinSel`, and the source that is not selected has no effect on `selIdx`.
- R3: An input counts as healthy when its loss of signal alarm is absent or masked and its out of frequency alarm is absent or masked. A masked alarm has no effect on `selIdx` or `holdReq`.
- R4: With `modeSel`=2'b10 (revertive), the selector picks the healthy input that has the smallest nonzero priority value. A tie goes to the lower index. The selector returns to a better input as soon as that input recovers.
- R5: An input whose 3-bit priority field (bits `3*i+2:3*i` of `prioBus`) is 0 is never chosen in either automatic mode, even when it is healthy.
- R6: With `modeSel`=2'b01 (non-revertive), the current input is kept while it is healthy and eligible, even if a better input exists. When the current input fails, the selector moves to the best eligible input.
- R7: In automatic modes with no eligible healthy input, `holdReq` is 1 and `selIdx` keeps its value. In manual mode `holdReq` is 1 exactly when the chosen input is unhealthy.
- R8: With `zeroDelayEn`=1, input 3 is never selected. A manual request for index 3 is ignored, and the selection holds. If input 3 is the current selection when zero-delay is enabled, the selection falls back to input 0.
- R9: `switchPulse` is 1 for exactly one cycle: the first cycle in which `selIdx` shows a new value.
- R10: `selIdx`, `switchPulse` and `holdReq` are registered. They change at the first rising clock edge after an input change and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | 00/11 manual, 01 automatic non-revertive, 10 automatic revertive |
| manualFromReg | input | 1 | Manual source: 1 register field, 0 pins |
| pinSel | input | 2 | Manual index from pins |
| regSel | input | 2 | Manual index from register |
| zeroDelayEn | input | 1 | Input 3 is feedback and not selectable |
| prioBus | input | 12 | Per-input 3-bit priorities; 1 is best, 0 excludes |
| losAlarm | input | 4 | Per-input loss of signal alarms |
| oofAlarm | input | 4 | Per-input out of frequency alarms |
| losMask | input | 4 | Per-input mask of loss of signal alarm |
| oofMask | input | 4 | Per-input mask of out of frequency alarm |
| selIdx | output | 2 | Chosen input index |
| switchPulse | output | 1 | One-cycle strobe on index change |
| holdReq | output | 1 | Request toward holdover |

## Verification
The bench first recovers a failed top-priority input in revertive mode and checks that the selection goes back. If the revertive and non-revertive cases were swapped, the selection would stay on the weaker input in one mode and jump in the other. It then places two inputs at the same priority, where a reversed tie rule picks index 1 instead of 0. It also keeps a healthy input at priority 0 as the only survivor, which a selector that treats zero as "lowest" would wrongly choose instead of raising a holdover request. Zero-delay is checked both with the feedback input already selected and with a manual request for it; a missing exclusion would leave index 3 on the output. Masked alarms, and the pin field while register control is active, are checked for having no effect, and the strobe is checked for going low again one cycle after each switch.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

  typedef enum logic [1:0] {
    MODE_MANUAL      = 2'b00,
    MODE_AUTO_STICKY = 2'b01,
    MODE_AUTO_REVERT = 2'b10,
    MODE_SPARE       = 2'b11
  } selMode_e;

  // Strobes from control toward the datapath
  typedef struct packed {
    logic load;      // take the new index this cycle
    logic noSource;  // nothing usable: ask for holdover
  } selStrobe_t;

endpackage

// File: rtl/ref_sel_qualify.sv
module ref_sel_qualify #(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned PRIO_W = 3
) (
  input  logic [NUM_IN-1:0]        losAlarm,
  input  logic [NUM_IN-1:0]        oofAlarm,
  input  logic [NUM_IN-1:0]        losMask,
  input  logic [NUM_IN-1:0]        oofMask,
  input  logic [NUM_IN*PRIO_W-1:0] prioBus,
  input  logic                     zeroDelayEn,
  output logic [NUM_IN-1:0]        validVec,
  output logic [NUM_IN-1:0]        blockedVec,
  output logic [NUM_IN-1:0]        eligVec
);

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    logic losHit;
    logic oofHit;
    assign losHit      = losAlarm[g] & ~losMask[g];
    assign oofHit      = oofAlarm[g] & ~oofMask[g];
    assign validVec[g] = ~(losHit | oofHit);

    // Last input doubles as the feedback path in zero-delay operation
    if (g == NUM_IN - 1) begin : g_fb
      assign blockedVec[g] = zeroDelayEn;
    end else begin : g_ref
      assign blockedVec[g] = 1'b0;
    end

    assign eligVec[g] = validVec[g] & ~blockedVec[g]
                      & (prioBus[g*PRIO_W +: PRIO_W] != '0);
  end

endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modeSel,
  input  logic                     manualFromReg,
  input  logic [IDX_W-1:0]         pinSel,
  input  logic [IDX_W-1:0]         regSel,
  input  logic [NUM_IN*PRIO_W-1:0] prioBus,
  input  logic [NUM_IN-1:0]        validVec,
  input  logic [NUM_IN-1:0]        blockedVec,
  input  logic [NUM_IN-1:0]        eligVec,
  input  logic                     zeroDelayEn,
  input  logic [IDX_W-1:0]         curIdx,
  output logic [IDX_W-1:0]         nextIdx,
  output selStrobe_t               strobe
);

  selMode_e mode;
  logic autoMode;
  logic curElig;
  logic anyElig;
  logic noSource;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  holdIdx;
  logic [IDX_W-1:0]  reqIdx;
  logic [IDX_W-1:0]  manualIdx;

  assign mode     = selMode_e'(modeSel);
  assign autoMode = (mode == MODE_AUTO_STICKY) || (mode == MODE_AUTO_REVERT);
  assign curElig  = eligVec[curIdx];

  // Index kept when no move is wanted; a blocked current falls back to 0
  assign holdIdx   = blockedVec[curIdx] ? '0 : curIdx;
  assign reqIdx    = manualFromReg ? regSel : pinSel;
  assign manualIdx = blockedVec[reqIdx] ? holdIdx : reqIdx;

  // Ranking: smallest nonzero priority wins, strict compare keeps lower index on ties
  always_comb begin
    bestIdx  = '0;
    bestPrio = '1;
    anyElig  = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (eligVec[i] && (!anyElig || (prioBus[i*PRIO_W +: PRIO_W] < bestPrio))) begin
        anyElig  = 1'b1;
        bestPrio = prioBus[i*PRIO_W +: PRIO_W];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    nextIdx  = holdIdx;
    noSource = 1'b0;
    if (!autoMode) begin
      nextIdx  = manualIdx;
      noSource = ~validVec[manualIdx];
    end else if ((mode == MODE_AUTO_STICKY) && curElig) begin
      nextIdx = curIdx;
    end else if (anyElig) begin
      nextIdx = bestIdx;
    end else begin
      nextIdx  = holdIdx;
      noSource = 1'b1;
    end
  end

  assign strobe.load     = (nextIdx != curIdx);
  assign strobe.noSource = noSource;

  // Assertion support: one cycle must pass after reset before looking back
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_FEEDBACK_NEVER_CHOSEN: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(zeroDelayEn)) |-> (curIdx != IDX_W'(NUM_IN - 1))); // R8

  AST_AUTO_PICKS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(autoMode && anyElig)) |->
      (($past(eligVec) & (NUM_IN'(1) << curIdx)) != '0)); // R5

  AST_HOLD_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(autoMode && !anyElig && !blockedVec[curIdx])) |->
      (curIdx == $past(curIdx))); // R7

  AST_STICKY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past((mode == MODE_AUTO_STICKY) && curElig)) |->
      (curIdx == $past(curIdx))); // R6

endmodule

// File: rtl/ref_sel_dp.sv
module ref_sel_dp
  import ref_sel_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] nextIdx,
  input  selStrobe_t       strobe,
  output logic [IDX_W-1:0] selIdx,
  output logic             switchPulse,
  output logic             holdReq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx      <= '0;
      switchPulse <= 1'b0;
      holdReq     <= 1'b0;
    end else begin
      if (strobe.load) selIdx <= nextIdx;
      switchPulse <= strobe.load;
      holdReq     <= strobe.noSource;
    end
  end

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && switchPulse) |-> (selIdx != $past(selIdx))); // R9

  AST_CHANGE_MEANS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (selIdx != $past(selIdx))) |-> switchPulse); // R9

endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modeSel,
  input  logic                     manualFromReg,
  input  logic [IDX_W-1:0]         pinSel,
  input  logic [IDX_W-1:0]         regSel,
  input  logic                     zeroDelayEn,
  input  logic [NUM_IN*PRIO_W-1:0] prioBus,
  input  logic [NUM_IN-1:0]        losAlarm,
  input  logic [NUM_IN-1:0]        oofAlarm,
  input  logic [NUM_IN-1:0]        losMask,
  input  logic [NUM_IN-1:0]        oofMask,
  output logic [IDX_W-1:0]         selIdx,
  output logic                     switchPulse,
  output logic                     holdReq
);

  logic [NUM_IN-1:0] validVec;
  logic [NUM_IN-1:0] blockedVec;
  logic [NUM_IN-1:0] eligVec;
  logic [IDX_W-1:0]  nextIdx;
  selStrobe_t        strobe;

  ref_sel_qualify #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W)) i_qualify (
    .losAlarm   (losAlarm),
    .oofAlarm   (oofAlarm),
    .losMask    (losMask),
    .oofMask    (oofMask),
    .prioBus    (prioBus),
    .zeroDelayEn(zeroDelayEn),
    .validVec   (validVec),
    .blockedVec (blockedVec),
    .eligVec    (eligVec)
  );

  ref_sel_ctrl #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeSel      (modeSel),
    .manualFromReg(manualFromReg),
    .pinSel       (pinSel),
    .regSel       (regSel),
    .prioBus      (prioBus),
    .validVec     (validVec),
    .blockedVec   (blockedVec),
    .eligVec      (eligVec),
    .zeroDelayEn  (zeroDelayEn),
    .curIdx       (selIdx),
    .nextIdx      (nextIdx),
    .strobe       (strobe)
  );

  ref_sel_dp #(.IDX_W(IDX_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .nextIdx    (nextIdx),
    .strobe     (strobe),
    .selIdx     (selIdx),
    .switchPulse(switchPulse),
    .holdReq    (holdReq)
  );

endmodule

// File: tb/test_ref_clk_selector.sv
`timescale 1ns/1ps
module test_ref_clk_selector;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modeSel;
  logic        manualFromReg;
  logic [1:0]  pinSel;
  logic [1:0]  regSel;
  logic        zeroDelayEn;
  logic [11:0] prioBus;
  logic [3:0]  losAlarm;
  logic [3:0]  oofAlarm;
  logic [3:0]  losMask;
  logic [3:0]  oofMask;
  logic [1:0]  selIdx;
  logic        switchPulse;
  logic        holdReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  ref_clk_selector i_ref_clk_selector (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .manualFromReg(manualFromReg),
    .pinSel(pinSel), .regSel(regSel), .zeroDelayEn(zeroDelayEn), .prioBus(prioBus),
    .losAlarm(losAlarm), .oofAlarm(oofAlarm), .losMask(losMask), .oofMask(oofMask),
    .selIdx(selIdx), .switchPulse(switchPulse), .holdReq(holdReq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expectOut(input string req, input int sel, input int pulse, input int hold);
    check(req, "selIdx", int'(selIdx), sel);
    check(req, "switchPulse", int'(switchPulse), pulse);
    check(req, "holdReq", int'(holdReq), hold);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Priorities given for inputs 0..3
  task automatic setPrio(input int p0, input int p1, input int p2, input int p3);
    prioBus = {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
  endtask

  task automatic testReset();
    rstN = 1'b0;
    modeSel = 2'b00; manualFromReg = 1'b0; pinSel = 2'd0; regSel = 2'd0;
    zeroDelayEn = 1'b0; prioBus = '0;
    losAlarm = '0; oofAlarm = '0; losMask = '0; oofMask = '0;
    repeat (3) @(posedge clk);
    #1;
    expectOut("R1", 0, 0, 0);
    rstN = 1'b1;
    step();
    expectOut("R1", 0, 0, 0);
  endtask

  task automatic testManual();
    pinSel = 2'd2;
    #1;
    check("R10", "selIdx before edge", int'(selIdx), 0);
    step();
    expectOut("R2", 2, 1, 0);
    step();
    expectOut("R9", 2, 0, 0);
    manualFromReg = 1'b1; regSel = 2'd1;
    step();
    expectOut("R2", 1, 1, 0);
    modeSel = 2'b11; regSel = 2'd3;
    step();
    expectOut("R2", 3, 1, 0);
    pinSel = 2'd0;   // not the active source
    step();
    expectOut("R2", 3, 0, 0);
  endtask

  task automatic testManualHold();
    losAlarm = 4'b1000;
    step();
    expectOut("R7", 3, 0, 1);
    losMask = 4'b1000;
    step();
    expectOut("R3", 3, 0, 0);
    oofAlarm = 4'b1000;
    step();
    expectOut("R3", 3, 0, 1);
    oofMask = 4'b1000;
    step();
    expectOut("R3", 3, 0, 0);
    losAlarm = '0; oofAlarm = '0; losMask = '0; oofMask = '0;
    step();
    expectOut("R3", 3, 0, 0);
  endtask

  task automatic testRevertive();
    modeSel = 2'b10;
    setPrio(3, 1, 2, 0);
    step();
    expectOut("R4", 1, 1, 0);
    losAlarm = 4'b0010;
    step();
    expectOut("R4", 2, 1, 0);
    losAlarm = 4'b0000;
    step();
    expectOut("R4", 1, 1, 0);
    setPrio(1, 1, 2, 0);
    step();
    expectOut("R4", 0, 1, 0);
    losAlarm = 4'b0111;   // only input 3 healthy, but priority 0
    step();
    expectOut("R5", 0, 0, 1);
    losAlarm = 4'b0000;
    step();
    expectOut("R7", 0, 0, 0);
  endtask

  task automatic testNonRevertive();
    modeSel = 2'b01;
    setPrio(3, 1, 2, 0);
    step();
    expectOut("R6", 0, 0, 0);
    losAlarm = 4'b0001;
    step();
    expectOut("R6", 1, 1, 0);
    losAlarm = 4'b0000;
    step();
    expectOut("R6", 1, 0, 0);
    losAlarm = 4'b0010;
    step();
    expectOut("R6", 2, 1, 0);
    losAlarm = 4'b0000;
    step();
    expectOut("R6", 2, 0, 0);
  endtask

  task automatic testZeroDelay();
    modeSel = 2'b10;
    setPrio(0, 0, 0, 1);
    step();
    expectOut("R8", 3, 1, 0);
    zeroDelayEn = 1'b1;
    step();
    expectOut("R8", 0, 1, 1);
    modeSel = 2'b00; manualFromReg = 1'b1; regSel = 2'd3;
    step();
    expectOut("R8", 0, 0, 0);
    regSel = 2'd2;
    step();
    expectOut("R8", 2, 1, 0);
    regSel = 2'd3;
    step();
    expectOut("R8", 2, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    testReset();
    testManual();
    testManualHold();
    testRevertive();
    testNonRevertive();
    testZeroDelay();
    summary();
    $finish;
  end

  initial begin
    #(20000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

endmodule